// File: doc/BRIEF.md
# BCD Calendar Timekeeper

This block is the counting core of a real-time clock. An oscillator-rate enable drives a sub-second prescaler, and the prescaler gives one pulse per second. That pulse advances a chain of packed-BCD counters: seconds, minutes, hours, weekday, day of month, month (with a century bit) and a two-digit year. The day counter follows month lengths and leap years.

Software reads and writes the seven time fields through a simple register port. The write side is synchronous. The read side is a combinational mux indexed by the read address. A mode input selects how the hours field is presented and accepted: 24-hour BCD, or 12-hour BCD with a PM bit. The hour is held internally as a binary 0–23 value, so changing the mode only changes how that value is shown.

A sticky invalid-time flag is raised by reset and by any oscillator-stop pulse. It stays set until software writes one of the time fields.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the fields read as seconds 00, minutes 00, hours 00 in 24-hour mode, weekday 0, day 01, month 01 with century bit 0, and year 00. The invalid flag reads 1 after reset.
- R2: Each field has a fixed register address: seconds 0, minutes 1, hours 2, weekday 3, day 4, month 5, year 6. A write loads the field in the same clock edge, masked to its width: seconds and minutes to 7 bits, weekday to 3 bits, day to 6 bits, month to bits 4:0 plus the century in bit 7, and year to 8 bits. Reading an address returns the stored field.
- R3: The seconds field advances once for every PRESC_DIV enabled oscillator cycles, and each advance is a BCD increment (09 becomes 10). Any register write restarts the prescaler, so the next advance comes PRESC_DIV oscillator cycles after the write.
- R4: When seconds are 59, the next advance sets seconds to 00 and carries into minutes. When minutes are 59 on that carry, minutes become 00 and the carry passes into hours.
- R5: In 24-hour mode, bits 5:0 of the hours register hold BCD 00–23. A carry out of hour 23 gives 00 and advances the day and the weekday. A written hour outside 00–23 loads as 00.
- R6: In 12-hour mode, bit 5 of the hours register is PM and bits 4:0 hold BCD 01–12. Midnight reads 0x12 and noon reads 0x32. 11 PM advances to 0x12 and 11 AM advances to 0x32. Switching the mode input re-encodes the hour that is already stored.
- R7: The weekday counts 0 to 6, and 6 wraps to 0 on a day carry.
- R8: The day wraps to 01 after day 31 in months 01, 03, 05, 07, 08, 10 and 12, after day 30 in months 04, 06, 09 and 11, and in month 02 after day 29 when the year is divisible by 4 and after day 28 otherwise. Each wrap advances the month.
- R9: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and inverts the century bit (month bit 7).
- R10: The invalid flag is set by a pulse on osc_fail and then stays set. A write to any of addresses 0–6 clears it. If osc_fail and such a write occur in the same cycle, the flag ends up set.
- R11: If a write occurs in the same cycle that a seconds advance is due, the written value is kept and the advance is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Oscillator-rate enable feeding the prescaler |
| osc_fail | input | 1 | Oscillator-stop pulse; sets the invalid flag |
| hour24 | input | 1 | 1 selects 24-hour encoding, 0 selects 12-hour encoding |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0–6) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| time_invalid | output | 1 | Sticky invalid-time flag |

## Verification
The bench drives the full carry chain from 23:59:58 on 31 December of year 99. A design that broke the ripple at any stage would leave a stale minute, hour, month or year, or fail to invert the century bit. February is run in a leap year and a common year, and 30-day months are run against 31-day months. A design with a wrong length table or leap test shows day 29 or 31 where it should show 01, or the reverse. In 12-hour mode the bench checks the 11 PM to midnight and 11 AM to noon transitions and a change of mode, which expose a design that encodes 0 or 12 as a bare BCD value. It also issues a write on the exact cycle a second is due, and places writes mid-second to restart the prescaler. A design that lost or doubled a carry here shows the next second one oscillator cycle early or late.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int HOUR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    RA_SEC  = 3'd0,
    RA_MIN  = 3'd1,
    RA_HOUR = 3'd2,
    RA_WDAY = 3'd3,
    RA_DAY  = 3'd4,
    RA_MON  = 3'd5,
    RA_YEAR = 3'd6
  } reg_addr_e;

  function automatic logic [DATA_W-1:0] bcd_inc(input logic [DATA_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [DATA_W-1:0] v);
    return (7'(v[7:4]) * 7'd10) + 7'(v[3:0]);
  endfunction

  function automatic logic [DATA_W-1:0] hour_to_bcd(input logic [HOUR_W-1:0] b);
    logic [3:0] tens;
    logic [HOUR_W-1:0] ones;
    if (b >= 5'd20)      begin tens = 4'd2; ones = b - 5'd20; end
    else if (b >= 5'd10) begin tens = 4'd1; ones = b - 5'd10; end
    else                 begin tens = 4'd0; ones = b; end
    return {tens, ones[3:0]};
  endfunction

  function automatic logic year_is_leap(input logic [DATA_W-1:0] y);
    logic [6:0] b;
    b = bcd_to_bin(y);
    return (b[1:0] == 2'd0);
  endfunction

  function automatic logic [DATA_W-1:0] month_last_day(input logic [DATA_W-1:0] mon,
                                                       input logic [DATA_W-1:0] yr);
    case (mon)
      8'h02:                      return year_is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic restart,
  output logic sec_tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)              cnt_d = '0;
    else if (osc_tick)        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign sec_tick = osc_tick && !restart && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: a write restarts the sub-second count
  a_r3_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_hour_codec.sv
module rtc_hour_codec
  import bcd_rtc_pkg::*;
(
  input  logic              hour24,
  input  logic [HOUR_W-1:0] hour_bin,
  input  logic [DATA_W-1:0] wr_byte,
  output logic [DATA_W-1:0] hour_reg,
  output logic [HOUR_W-1:0] wr_hour
);
  logic [6:0] h12_raw, h24_raw, h12_dec;

  // encode stored 0..23 into the selected register format
  always_comb begin
    if (hour24)                 hour_reg = hour_to_bcd(hour_bin);
    else if (hour_bin == 5'd0)  hour_reg = 8'h12;
    else if (hour_bin < 5'd12)  hour_reg = hour_to_bcd(hour_bin);
    else if (hour_bin == 5'd12) hour_reg = 8'h32;
    else                        hour_reg = 8'h20 | hour_to_bcd(hour_bin - 5'd12);
  end

  // decode a written byte back into 0..23; out-of-range loads zero
  always_comb begin
    h24_raw = bcd_to_bin({2'b00, wr_byte[5:0]});
    h12_raw = bcd_to_bin({3'b000, wr_byte[4:0]});
    h12_dec = (h12_raw == 7'd12) ? 7'd0 : h12_raw;
    if (wr_byte[5]) h12_dec = h12_dec + 7'd12;
    if (hour24) wr_hour = (h24_raw < 7'd24) ? h24_raw[HOUR_W-1:0] : '0;
    else        wr_hour = (h12_raw >= 7'd1 && h12_raw <= 7'd12) ? h12_dec[HOUR_W-1:0] : '0;
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import bcd_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [HOUR_W-1:0] ld_hour,
  output logic [DATA_W-1:0] sec_o,
  output logic [DATA_W-1:0] min_o,
  output logic [HOUR_W-1:0] hour_o,
  output logic [DATA_W-1:0] wday_o,
  output logic [DATA_W-1:0] day_o,
  output logic [DATA_W-1:0] mon_o,
  output logic              cent_o,
  output logic [DATA_W-1:0] year_o
);
  logic [DATA_W-1:0] sec_q, min_q, wday_q, day_q, mon_q, year_q;
  logic [DATA_W-1:0] sec_d, min_d, wday_d, day_d, mon_d, year_d;
  logic [HOUR_W-1:0] hour_q, hour_d;
  logic              cent_q, cent_d;
  logic              c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    sec_d = sec_q; min_d = min_q; hour_d = hour_q; wday_d = wday_q;
    day_d = day_q; mon_d = mon_q; year_d = year_q; cent_d = cent_q;

    c_min = sec_tick && (sec_q  >= 8'h59);
    c_hr  = c_min    && (min_q  >= 8'h59);
    c_day = c_hr     && (hour_q >= 5'd23);
    c_mon = c_day    && (day_q  >= month_last_day(mon_q, year_q));
    c_yr  = c_mon    && (mon_q  >= 8'h12);

    if (sec_tick) sec_d  = c_min ? 8'h00 : bcd_inc(sec_q);
    if (c_min)    min_d  = c_hr  ? 8'h00 : bcd_inc(min_q);
    if (c_hr)     hour_d = c_day ? '0    : hour_q + 1'b1;
    if (c_day) begin
      wday_d = (wday_q >= 8'h06) ? 8'h00 : wday_q + 8'h01;
      day_d  = c_mon ? 8'h01 : bcd_inc(day_q);
    end
    if (c_mon)    mon_d  = c_yr ? 8'h01 : bcd_inc(mon_q);
    if (c_yr) begin
      year_d = (year_q >= 8'h99) ? 8'h00 : bcd_inc(year_q);
      if (year_q >= 8'h99) cent_d = ~cent_q;
    end

    if (ld_en) begin
      case (ld_addr)
        RA_SEC:  sec_d  = {1'b0, ld_data[6:0]};
        RA_MIN:  min_d  = {1'b0, ld_data[6:0]};
        RA_HOUR: hour_d = ld_hour;
        RA_WDAY: wday_d = {5'd0, ld_data[2:0]};
        RA_DAY:  day_d  = {2'd0, ld_data[5:0]};
        RA_MON:  begin mon_d = {3'd0, ld_data[4:0]}; cent_d = ld_data[7]; end
        RA_YEAR: year_d = ld_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= 8'h00; min_q <= 8'h00; hour_q <= '0; wday_q <= 8'h00;
      day_q <= 8'h01; mon_q <= 8'h01; year_q <= 8'h00; cent_q <= 1'b0;
    end else begin
      sec_q <= sec_d; min_q <= min_d; hour_q <= hour_d; wday_q <= wday_d;
      day_q <= day_d; mon_q <= mon_d; year_q <= year_d; cent_q <= cent_d;
    end
  end

  assign sec_o = sec_q;  assign min_o = min_q;  assign hour_o = hour_q;
  assign wday_o = wday_q; assign day_o = day_q; assign mon_o = mon_q;
  assign cent_o = cent_q; assign year_o = year_q;

  // R4: second 59 wraps to 00 on an advance
  a_r4_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !ld_en && sec_q == 8'h59) |=> (sec_q == 8'h00));

  // R5: stored hour never leaves 0..23
  a_r5_hour_range: assert property (@(posedge clk) disable iff (!rst_n)
    hour_q < 5'd24);

  // R9: year wrap inverts the century bit
  a_r9_century_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (c_yr && !ld_en && year_q == 8'h99) |=> (cent_q != $past(cent_q)));

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import bcd_rtc_pkg::*;
#(
  parameter int PRESC_DIV = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              osc_fail,
  input  logic              hour24,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              time_invalid
);
  logic              time_wr, sec_tick;
  logic [HOUR_W-1:0] hour_bin, wr_hour;
  logic [DATA_W-1:0] sec, min, wday, day, mon, year, hour_reg;
  logic              cent;
  logic              inval_q, inval_d;

  assign time_wr = wr_en && (wr_addr <= RA_YEAR);

  rtc_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .restart(wr_en), .sec_tick(sec_tick)
  );

  rtc_hour_codec u_codec (
    .hour24(hour24), .hour_bin(hour_bin), .wr_byte(wr_data),
    .hour_reg(hour_reg), .wr_hour(wr_hour)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .ld_en(time_wr), .ld_addr(wr_addr), .ld_data(wr_data), .ld_hour(wr_hour),
    .sec_o(sec), .min_o(min), .hour_o(hour_bin), .wday_o(wday),
    .day_o(day), .mon_o(mon), .cent_o(cent), .year_o(year)
  );

  always_comb begin
    inval_d = inval_q;
    if (time_wr)  inval_d = 1'b0;
    if (osc_fail) inval_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inval_q <= 1'b1;
    else        inval_q <= inval_d;
  end

  assign time_invalid = inval_q;

  always_comb begin
    case (rd_addr)
      RA_SEC:  rd_data = sec;
      RA_MIN:  rd_data = min;
      RA_HOUR: rd_data = hour_reg;
      RA_WDAY: rd_data = wday;
      RA_DAY:  rd_data = day;
      RA_MON:  rd_data = {cent, 2'b00, mon[4:0]};
      RA_YEAR: rd_data = year;
      default: rd_data = '0;
    endcase
  end

  // R10: flag holds unless a time write clears it
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (time_invalid && !time_wr) |=> time_invalid);

  // R10: oscillator stop always leaves the flag set
  a_r10_fail_sets: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fail |=> time_invalid);

  // R11: a seconds write is kept even when an advance was due
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == RA_SEC) |=> (sec == {1'b0, $past(wr_data[6:0])}));

endmodule

// File: tb/sim_bcd_rtc_core.sv
module sim_bcd_rtc_core;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int FLAG_ADDR = 8;

  logic       clk, rst_n, osc_tick, osc_fail, hour24, wr_en;
  logic [2:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       time_invalid;

  typedef struct {
    int         addr;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    outstanding = 0;
  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;

  bcd_rtc_core #(.PRESC_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .osc_fail(osc_fail),
    .hour24(hour24), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .time_invalid(time_invalid)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // monitor: pops expected items and compares against the port
  initial begin
    rd_addr = 3'd0;
    forever begin
      wait (q.size() != 0);
      begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        if (it.addr != FLAG_ADDR) rd_addr = it.addr[2:0];
        #1;
        act = (it.addr == FLAG_ADDR) ? {7'd0, time_invalid} : rd_data;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s addr %0d: actual 0x%02h expected 0x%02h", it.tag, it.addr, act, it.exp);
        end
        outstanding--;
      end
    end
  end

  task automatic expect_reg(input int addr, input logic [7:0] exp, input string tag);
    item_t it;
    it.addr = addr; it.exp = exp; it.tag = tag;
    outstanding++;
    q.push_back(it);
    wait (outstanding == 0);
  endtask

  task automatic wr(input int addr, input logic [7:0] data, input bit tick);
    wr_en = 1'b1; wr_addr = addr[2:0]; wr_data = data; osc_tick = tick;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; osc_tick = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    osc_tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    osc_tick = 1'b0;
  endtask

  task automatic set_hms(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(2, h, 1'b0); wr(1, m, 1'b0); wr(0, s, 1'b0);
  endtask

  task automatic set_date(input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
    wr(4, d, 1'b0); wr(5, mo, 1'b0); wr(6, y, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; osc_tick = 1'b0; osc_fail = 1'b0; hour24 = 1'b1;
    wr_en = 1'b0; wr_addr = 3'd0; wr_data = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_reg(0, 8'h00, "R1");
    expect_reg(1, 8'h00, "R1");
    expect_reg(2, 8'h00, "R1");
    expect_reg(3, 8'h00, "R1");
    expect_reg(4, 8'h01, "R1");
    expect_reg(5, 8'h01, "R1");
    expect_reg(6, 8'h00, "R1");
    expect_reg(FLAG_ADDR, 8'h01, "R1");

    // R2 load and masking, R10 clear on write
    wr(0, 8'h45, 1'b0);
    expect_reg(0, 8'h45, "R2");
    expect_reg(FLAG_ADDR, 8'h00, "R10");
    wr(4, 8'hFF, 1'b0);
    expect_reg(4, 8'h3F, "R2");
    wr(5, 8'hFF, 1'b0);
    expect_reg(5, 8'h9F, "R2");
    wr(3, 8'hFF, 1'b0);
    expect_reg(3, 8'h07, "R2");
    wr(1, 8'hC3, 1'b0);
    expect_reg(1, 8'h43, "R2");
    set_date(8'h10, 8'h05, 8'h30);
    wr(3, 8'h02, 1'b0);

    // R3 prescaler rate and restart, R11 write wins
    wr(0, 8'h10, 1'b0);
    run_ticks(DIV - 1);
    expect_reg(0, 8'h10, "R3");
    run_ticks(1);
    expect_reg(0, 8'h11, "R3");
    run_ticks(DIV - 1);
    wr(0, 8'h20, 1'b1);
    expect_reg(0, 8'h20, "R11");
    run_ticks(DIV - 1);
    expect_reg(0, 8'h20, "R3");
    run_ticks(1);
    expect_reg(0, 8'h21, "R3");
    wr(0, 8'h09, 1'b0);
    run_ticks(DIV);
    expect_reg(0, 8'h10, "R3");

    // R4 minute and hour carry
    set_hms(8'h05, 8'h59, 8'h59);
    run_ticks(DIV);
    expect_reg(0, 8'h00, "R4");
    expect_reg(1, 8'h00, "R4");
    expect_reg(2, 8'h06, "R4");

    // R5 R7 R9 full rollover at end of century
    wr(3, 8'h06, 1'b0);
    set_date(8'h31, 8'h12, 8'h99);
    set_hms(8'h23, 8'h59, 8'h58);
    run_ticks(2 * DIV);
    expect_reg(0, 8'h00, "R5");
    expect_reg(2, 8'h00, "R5");
    expect_reg(3, 8'h00, "R7");
    expect_reg(4, 8'h01, "R9");
    expect_reg(5, 8'h81, "R9");
    expect_reg(6, 8'h00, "R9");
    wr(2, 8'h25, 1'b0);
    expect_reg(2, 8'h00, "R5");

    // R6 12-hour encoding
    @(negedge clk); hour24 = 1'b0;
    set_date(8'h05, 8'h03, 8'h21);
    set_hms(8'h31, 8'h59, 8'h59);
    run_ticks(DIV);
    expect_reg(2, 8'h12, "R6");
    expect_reg(4, 8'h06, "R6");
    set_hms(8'h11, 8'h59, 8'h59);
    run_ticks(DIV);
    expect_reg(2, 8'h32, "R6");
    @(negedge clk); hour24 = 1'b1;
    expect_reg(2, 8'h12, "R6");
    wr(2, 8'h00, 1'b0);
    @(negedge clk); hour24 = 1'b0;
    expect_reg(2, 8'h12, "R6");
    wr(2, 8'h27, 1'b0);
    @(negedge clk); hour24 = 1'b1;
    expect_reg(2, 8'h19, "R6");

    // R8 month lengths
    set_date(8'h28, 8'h02, 8'h23);
    set_hms(8'h23, 8'h59, 8'h59);
    run_ticks(DIV);
    expect_reg(4, 8'h01, "R8");
    expect_reg(5, 8'h03, "R8");
    set_date(8'h28, 8'h02, 8'h24);
    set_hms(8'h23, 8'h59, 8'h59);
    run_ticks(DIV);
    expect_reg(4, 8'h29, "R8");
    expect_reg(5, 8'h02, "R8");
    set_hms(8'h23, 8'h59, 8'h59);
    run_ticks(DIV);
    expect_reg(4, 8'h01, "R8");
    expect_reg(5, 8'h03, "R8");
    set_date(8'h30, 8'h04, 8'h24);
    set_hms(8'h23, 8'h59, 8'h59);
    run_ticks(DIV);
    expect_reg(4, 8'h01, "R8");
    expect_reg(5, 8'h05, "R8");
    set_date(8'h30, 8'h11, 8'h24);
    set_hms(8'h23, 8'h59, 8'h59);
    run_ticks(DIV);
    expect_reg(4, 8'h01, "R8");
    expect_reg(5, 8'h12, "R8");
    set_date(8'h30, 8'h01, 8'h24);
    set_hms(8'h23, 8'h59, 8'h59);
    run_ticks(DIV);
    expect_reg(4, 8'h31, "R8");
    expect_reg(5, 8'h01, "R8");

    // R9 month 12 wrap without century change
    set_date(8'h31, 8'h12, 8'h24);
    set_hms(8'h23, 8'h59, 8'h59);
    run_ticks(DIV);
    expect_reg(5, 8'h01, "R9");
    expect_reg(6, 8'h25, "R9");

    // R10 sticky flag
    osc_fail = 1'b1;
    @(posedge clk); @(negedge clk);
    osc_fail = 1'b0;
    expect_reg(FLAG_ADDR, 8'h01, "R10");
    run_ticks(2 * DIV);
    expect_reg(FLAG_ADDR, 8'h01, "R10");
    wr(1, 8'h10, 1'b0);
    expect_reg(FLAG_ADDR, 8'h00, "R10");
    osc_fail = 1'b1;
    wr(1, 8'h11, 1'b0);
    osc_fail = 1'b0;
    expect_reg(FLAG_ADDR, 8'h01, "R10");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule